// File: doc/BRIEF.md
# SPI Serial Clock and Delay Timing Generator

This block turns a fixed system clock into the serial clock of an SPI master, together with the three chip-select delays that surround each frame. A frame engine hands it a 24-bit timing word and a bit count through a valid/ready start handshake. The block then runs one frame in a fixed order. It first holds off for the select-to-clock lead delay. It then emits the requested number of SCK periods, holds the trail delay before the select is released, and finally waits out the inter-frame gap. One-cycle strobes mark every SCK edge and the end of each delay, so the engine can shift data and drive its select pins in step.

Every length is a product of two coded factors. The SCK period uses a small prime prescaler and an even scaler. Each delay uses an odd prescaler and a power-of-two scaler. The start handshake applies back-pressure in the usual way. `start_ready` is high only while the generator is idle. A start counts only on a clock edge where `start_valid` and `start_ready` are both high. While a frame runs, a held `start_valid` waits. Nothing is lost and no second frame is queued.

Top module: `spi_tgen`

## Requirements
- R1: The baud prescaler field cfg_in[17:16] selects a factor of 2, 3, 5 or 7 for codes 0, 1, 2, 3.
- R2: The baud scaler field cfg_in[3:0] selects 2, 4 or 6 for codes 0..2, and 2^code for codes 3..15 (8 up to 32768). The SCK period in system clocks is the prescaler factor times the scaler factor.
- R3: SCK idles low. Each period begins with a rising edge. The high half lasts ceil(period/2) clocks and the low half lasts floor(period/2) clocks.
- R4: Each delay lasts (2p+1) * 2^(s+1) clocks, where p is a 2-bit prescaler code and s is a 4-bit scaler code. The lead delay uses p=cfg_in[23:22] and s=cfg_in[15:12]. The trail delay uses p=cfg_in[21:20] and s=cfg_in[11:8]. The gap delay uses p=cfg_in[19:18] and s=cfg_in[7:4].
- R5: When a start is accepted on edge E0, cs_active rises on E0. The first SCK rise comes lead clocks later. bits_in+1 full SCK periods follow. cs_active falls trail clocks after the last low half ends. The gap delay then runs.
- R6: sck_rise_pls and sck_fall_pls are high for the one cycle after the matching SCK edge. lead_done_pls coincides with the first rise. trail_done_pls coincides with the fall of cs_active. gap_done_pls marks the edge on which the generator returns to idle.
- R7: cfg_in and bits_in are captured only at an accepted start. Changing them during a frame does not alter that frame.
- R8: start_ready is high only in idle, from reset and from the gap_done_pls edge onward. A start_valid held high during a frame produces no extra SCK edges.
- R9: While rst_n is low, and again after it is released, sck and cs_active are low, all strobes are low and start_ready is high. This also holds when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Frame start request |
| start_ready | output | 1 | Generator idle, start can be taken |
| cfg_in | input | 24 | Timing word (prescaler and scaler codes) |
| bits_in | input | 4 | Frame length minus one, in SCK periods |
| sck | output | 1 | Serial clock |
| cs_active | output | 1 | Chip select asserted (active high) |
| sck_rise_pls | output | 1 | Strobe after each SCK rising edge |
| sck_fall_pls | output | 1 | Strobe after each SCK falling edge |
| lead_done_pls | output | 1 | Lead delay expired |
| trail_done_pls | output | 1 | Trail delay expired, select released |
| gap_done_pls | output | 1 | Gap delay expired, generator idle |

## Verification
The checker watches the relations that must hold on every cycle. SCK must never be high without the select. Every SCK transition must carry its strobe. The lead strobe must line up with the first rise. The select may fall only with the trail strobe. The captured timing word must stay frozen mid-frame. Ready must never coexist with an active select. Whether each code maps to the right number of clocks can only be seen from the bench's timed frames, which measure the lead, half-period, frame and gap lengths. The bench also covers the scenarios that need a history of stimulus: a timing word scrambled mid-frame, a held start request, and a reset in the middle of a frame.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;
  localparam int PSC_W = 2;
  localparam int SCL_W = 4;
  localparam int CFG_W = 4 * (PSC_W + SCL_W);
  // longest delay: 7 * 2^(2^SCL_W) needs 3 + 2^SCL_W bits
  localparam int CNT_W = (1 << SCL_W) + 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SCK,
    PH_TRAIL,
    PH_GAP
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] trail_len;
    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] sck_hi;
    logic [CNT_W-1:0] sck_lo;
  } timing_t;

  function automatic logic [CNT_W-1:0] baud_psc_val(input logic [PSC_W-1:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      2'd0:    v = CNT_W'(2);
      2'd1:    v = CNT_W'(3);
      2'd2:    v = CNT_W'(5);
      default: v = CNT_W'(7);
    endcase
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] baud_scl_val(input logic [SCL_W-1:0] code);
    logic [CNT_W-1:0] v;
    if (code < SCL_W'(3)) v = CNT_W'({code, 1'b0}) + CNT_W'(2);
    else                  v = CNT_W'(1) << code;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] delay_val(input logic [PSC_W-1:0] p,
                                                 input logic [SCL_W-1:0] s);
    logic [SCL_W:0] sh;
    sh = {1'b0, s} + (SCL_W+1)'(1);
    return CNT_W'({p, 1'b1}) << sh;
  endfunction
endpackage

// File: rtl/spi_tgen_lut.sv
module spi_tgen_lut
  import spi_tgen_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output timing_t          tim
);
  localparam int NUM_DLY = 3;
  // delay order: lead, trail, gap
  localparam int PSC_LSB [NUM_DLY] = '{22, 20, 18};
  localparam int SCL_LSB [NUM_DLY] = '{12, 8, 4};
  localparam int BAUD_PSC_LSB = 16;
  localparam int BAUD_SCL_LSB = 0;

  logic [CNT_W-1:0] dly [NUM_DLY];
  logic [CNT_W-1:0] period;

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
    assign dly[g] = delay_val(cfg[PSC_LSB[g] +: PSC_W], cfg[SCL_LSB[g] +: SCL_W]);
  end

  assign period = baud_psc_val(cfg[BAUD_PSC_LSB +: PSC_W])
                * baud_scl_val(cfg[BAUD_SCL_LSB +: SCL_W]);

  always_comb begin
    tim.lead_len  = dly[0];
    tim.trail_len = dly[1];
    tim.gap_len   = dly[2];
    tim.sck_hi    = (period + CNT_W'(1)) >> 1;
    tim.sck_lo    = period >> 1;
  end
endmodule

// File: rtl/spi_tgen_cnt.sv
module spi_tgen_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= '0;
    else if (load)            q <= load_val;
    else if (dec && q != '0)  q <= q - W'(1);
  end

  assign zero = (q == '0);
endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
  import spi_tgen_pkg::*;
#(
  parameter int BITS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic [BITS_W-1:0] bits_in,
  output logic              sck,
  output logic              cs_active,
  output logic              sck_rise_pls,
  output logic              sck_fall_pls,
  output logic              lead_done_pls,
  output logic              trail_done_pls,
  output logic              gap_done_pls
);
  phase_e           phase;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_sel;
  timing_t          tim;
  logic             accept;
  logic             ph_zero, bit_zero;
  logic             ph_load, bit_dec;
  logic [CNT_W-1:0] ph_len;

  assign start_ready = (phase == PH_IDLE);
  assign accept      = start_valid && start_ready;
  // the lead length is needed on the accept edge itself
  assign cfg_sel     = accept ? cfg_in : cfg_q;

  spi_tgen_lut u_lut (
    .cfg (cfg_sel),
    .tim (tim)
  );

  // next phase length, minus one, chosen by where the frame is
  always_comb begin
    ph_load = 1'b0;
    ph_len  = '0;
    bit_dec = 1'b0;
    if (accept) begin
      ph_load = 1'b1;
      ph_len  = tim.lead_len;
    end else if (ph_zero) begin
      case (phase)
        PH_LEAD: begin
          ph_load = 1'b1;
          ph_len  = tim.sck_hi;
        end
        PH_SCK: begin
          ph_load = 1'b1;
          if (sck)           ph_len = tim.sck_lo;
          else if (bit_zero) ph_len = tim.trail_len;
          else begin
            ph_len  = tim.sck_hi;
            bit_dec = 1'b1;
          end
        end
        PH_TRAIL: begin
          ph_load = 1'b1;
          ph_len  = tim.gap_len;
        end
        default: ph_load = 1'b0;
      endcase
    end
  end

  spi_tgen_cnt #(.W(CNT_W)) u_ph_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_len - CNT_W'(1)),
    .dec      (phase != PH_IDLE),
    .zero     (ph_zero)
  );

  spi_tgen_cnt #(.W(BITS_W)) u_bit_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (bits_in),
    .dec      (bit_dec),
    .zero     (bit_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase          <= PH_IDLE;
      cfg_q          <= '0;
      sck            <= 1'b0;
      cs_active      <= 1'b0;
      sck_rise_pls   <= 1'b0;
      sck_fall_pls   <= 1'b0;
      lead_done_pls  <= 1'b0;
      trail_done_pls <= 1'b0;
      gap_done_pls   <= 1'b0;
    end else begin
      sck_rise_pls   <= 1'b0;
      sck_fall_pls   <= 1'b0;
      lead_done_pls  <= 1'b0;
      trail_done_pls <= 1'b0;
      gap_done_pls   <= 1'b0;
      if (accept) begin
        phase     <= PH_LEAD;
        cfg_q     <= cfg_in;
        cs_active <= 1'b1;
      end else if (ph_zero) begin
        case (phase)
          PH_LEAD: begin
            phase         <= PH_SCK;
            sck           <= 1'b1;
            sck_rise_pls  <= 1'b1;
            lead_done_pls <= 1'b1;
          end
          PH_SCK: begin
            if (sck) begin
              sck          <= 1'b0;
              sck_fall_pls <= 1'b1;
            end else if (bit_zero) begin
              phase <= PH_TRAIL;
            end else begin
              sck          <= 1'b1;
              sck_rise_pls <= 1'b1;
            end
          end
          PH_TRAIL: begin
            phase          <= PH_GAP;
            cs_active      <= 1'b0;
            trail_done_pls <= 1'b1;
          end
          PH_GAP: begin
            phase        <= PH_IDLE;
            gap_done_pls <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_tgen_chk.sv
module spi_tgen_chk
  import spi_tgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_ready,
  input logic             sck,
  input logic             cs_active,
  input logic             sck_rise_pls,
  input logic             sck_fall_pls,
  input logic             lead_done_pls,
  input logic             trail_done_pls,
  input logic             gap_done_pls,
  input logic [CFG_W-1:0] cfg_q
);
  p_sck_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> cs_active);

  p_ready_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (!cs_active && !sck));

  p_edge_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> (sck_rise_pls || sck_fall_pls));

  p_rise_is_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_pls |-> (sck && !$past(sck)));

  p_lead_with_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_done_pls |-> sck_rise_pls);

  p_cs_drop_trail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_active) |-> trail_done_pls);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_rise_pls, sck_fall_pls, trail_done_pls, gap_done_pls}));

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ready && !$past(start_ready)) |-> $stable(cfg_q));
endmodule

bind spi_tgen spi_tgen_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_ready    (start_ready),
  .sck            (sck),
  .cs_active      (cs_active),
  .sck_rise_pls   (sck_rise_pls),
  .sck_fall_pls   (sck_fall_pls),
  .lead_done_pls  (lead_done_pls),
  .trail_done_pls (trail_done_pls),
  .gap_done_pls   (gap_done_pls),
  .cfg_q          (cfg_q)
);

// File: tb/spi_tgen_test.sv
module spi_tgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [23:0] cfg_in = '0;
  logic [3:0]  bits_in = '0;
  logic        sck, cs_active, sck_rise_pls, sck_fall_pls;
  logic        lead_done_pls, trail_done_pls, gap_done_pls;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  spi_tgen uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_valid    (start_valid),
    .start_ready    (start_ready),
    .cfg_in         (cfg_in),
    .bits_in        (bits_in),
    .sck            (sck),
    .cs_active      (cs_active),
    .sck_rise_pls   (sck_rise_pls),
    .sck_fall_pls   (sck_fall_pls),
    .lead_done_pls  (lead_done_pls),
    .trail_done_pls (trail_done_pls),
    .gap_done_pls   (gap_done_pls)
  );

  // stimulus vectors: timing word, bit code, expected lead, period, trail, gap
  localparam int NV = 6;
  localparam int V_CFG   [NV] = '{24'h000000, 24'h6D1021, 24'hC63402, 24'hB32153, 24'h006664, 24'h00000F};
  localparam int V_NB    [NV] = '{0, 3, 7, 15, 1, 0};
  localparam int V_LEAD  [NV] = '{2, 12, 112, 40, 128, 2};
  localparam int V_PER   [NV] = '{4, 12, 30, 56, 32, 65536};
  localparam int V_TRAIL [NV] = '{2, 10, 32, 28, 128, 2};
  localparam int V_GAP   [NV] = '{2, 56, 6, 64, 128, 2};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [23:0] c, input logic [3:0] nb,
                           input bit hold, input bit scramble,
                           output int t_rise1, output int t_fall1, output int n_rise,
                           output int t_trail, output int t_gap,
                           output int cs_bad, output int rdy_bad);
    int k;
    t_rise1 = -1; t_fall1 = -1; n_rise = 0; t_trail = -1; t_gap = -1;
    cs_bad = 0; rdy_bad = 0; k = 0;
    @(negedge clk);
    start_valid = 1'b1; cfg_in = c; bits_in = nb;
    @(posedge clk); #1;
    if (!hold) start_valid = 1'b0;
    if (scramble) begin cfg_in = ~c; bits_in = ~nb; end
    while (!timed_out) begin
      @(posedge clk); #1;
      k++;
      if (sck_rise_pls) begin
        n_rise++;
        if (t_rise1 < 0) t_rise1 = k;
      end
      if (sck_fall_pls && t_fall1 < 0) t_fall1 = k;
      if (t_trail < 0 && !trail_done_pls && !cs_active) cs_bad++;
      if (trail_done_pls) t_trail = k;
      if (gap_done_pls) begin
        t_gap = k;
        break;
      end
      if (start_ready) rdy_bad++;
    end
    start_valid = 1'b0;
  endtask

  task automatic check_vec(input int i, input bit hold, input bit scramble, input string tag);
    int r1, f1, nr, tt, tg, cb, rb, nbits, half;
    run_frame(V_CFG[i][23:0], V_NB[i][3:0], hold, scramble, r1, f1, nr, tt, tg, cb, rb);
    nbits = V_NB[i] + 1;
    half  = (V_PER[i] + 1) / 2;
    chk({tag, " R4 R5 lead delay to first rise"}, r1, V_LEAD[i]);
    chk({tag, " R3 high half"}, f1 - r1, half);
    chk({tag, " R5 rise count"}, nr, nbits);
    chk({tag, " R1 R2 R4 trail end"}, tt, V_LEAD[i] + nbits * V_PER[i] + V_TRAIL[i]);
    chk({tag, " R4 gap length"}, tg - tt, V_GAP[i]);
    chk({tag, " R5 cs held through frame"}, cb, 0);
    chk({tag, " R8 ready low while busy"}, rb, 0);
    chk({tag, " R6 ready after gap"}, int'(start_ready), 1);
    chk({tag, " R6 cs low after trail"}, int'(cs_active), 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !timed_out) begin
      timed_out = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 reset sck", int'(sck), 0);
    chk("R9 reset cs", int'(cs_active), 0);
    chk("R9 reset ready", int'(start_ready), 1);
    chk("R9 reset strobes", int'({sck_rise_pls, sck_fall_pls, lead_done_pls, trail_done_pls, gap_done_pls}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) check_vec(i, 1'b0, 1'b0, $sformatf("vec%0d", i));

    // R7: inputs scrambled right after the accept edge
    check_vec(1, 1'b0, 1'b1, "scramble R7");
    // R8: start_valid held for the whole frame
    check_vec(2, 1'b1, 1'b0, "hold R8");

    // R9: reset in the middle of a frame
    @(negedge clk);
    start_valid = 1'b1; cfg_in = V_CFG[4][23:0]; bits_in = V_NB[4][3:0];
    @(posedge clk); #1;
    start_valid = 1'b0;
    repeat (140) @(posedge clk);
    #1;
    chk("R9 mid-frame cs active before reset", int'(cs_active), 1);
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R9 mid-frame reset sck", int'(sck), 0);
    chk("R9 mid-frame reset cs", int'(cs_active), 0);
    chk("R9 mid-frame reset ready", int'(start_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    check_vec(0, 1'b0, 1'b0, "after reset R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule